// File: doc/BRIEF.md
# Jittered-Sampling Bit Generation Controller

This block is the synchronous sequencer around a two-oscillator random bit source. For each bit it starts a slow ring oscillator and arms a fast one, drives a coarse-plus-fine delay code to the external delay line that retards the fast oscillator's start, holds the slow ring's length-modulating shift register and the sampling flip-flop in reset between bits, and captures the sampled value into an output register when the bit period ends.

Each bit is requested with a single-cycle `go` while the block is idle. The run phase lasts a programmable number of system clocks, so every bit starts and stops at a fixed phase of the system clock. After the capture cycle the delay code moves one step towards the sampled value: up after a 1, down after a 0, clamped at both ends. This keeps sampling near the fast oscillator's edges. During the run phase the block also synchronizes the slow oscillator, divides its rising edges by a prescale factor, and counts the divided ticks.

Top module: `jitter_bit_ctrl`

## Requirements
- R1: After reset the block is idle. `slow_en`, `fast_arm`, `done`, `busy` and `bit_out` are 0. `lfsr_rst` and `samp_rst` are 1. The combined code {coarse_code, fine_code} is mid-range: coarse 4, fine 0, value 64.
- R2: A `go` seen at a clock edge while idle starts a run. From the next cycle, `slow_en`, `fast_arm` and `busy` are 1 and `lfsr_rst` and `samp_rst` are 0. This lasts for max(pulse_len,1) cycles.
- R3: `go` while `busy` is 1 is ignored. It neither lengthens the run nor starts a second bit.
- R4: The run is followed by exactly one capture cycle. In that cycle both enables are 0, `samp_rst` is still 0 and `busy` is 1. At the end of the cycle `bit_out` takes `sample_in`. From the next cycle both resets are 1 again.
- R5: `done` is 1 for exactly the one cycle after the capture cycle. In that cycle `busy` is 0 and `bit_out` already shows the new bit.
- R6: The combined code is 16*coarse+fine. It rises by one after a captured 1 and falls by one after a captured 0, so fine 15 plus one gives fine 0 with coarse plus one.
- R7: The code saturates at 127 (coarse 7, fine 15) and at 0.
- R8: The code and `bit_out` change only in the cycle in which `done` is 1, and never while `busy` is 1.
- R9: `slow_osc` passes through two synchronizing flops. During the run phase, every 4th rising edge increments `tick_cnt` (8 bits, wrapping). `tick_cnt` and the prescaler clear when a run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Bit request strobe |
| pulse_len | input | 8 | Run length in system clocks (0 treated as 1) |
| slow_osc | input | 1 | Slow oscillator output, asynchronous |
| sample_in | input | 1 | Sampling flip-flop output |
| slow_en | output | 1 | Slow oscillator enable |
| fast_arm | output | 1 | Fast oscillator enable, before the external delay line |
| lfsr_rst | output | 1 | Reset for the ring-length shift register |
| samp_rst | output | 1 | Reset for the sampling flip-flop |
| coarse_code | output | 3 | Coarse delay code |
| fine_code | output | 4 | Fine delay code |
| bit_out | output | 1 | Captured random bit |
| done | output | 1 | One-cycle strobe after capture |
| busy | output | 1 | Bit in flight |
| tick_cnt | output | 8 | Prescaled slow-oscillator ticks this bit |

## Verification
The code limits are the hardest state to reach. The code starts at mid-range and moves by one per bit, so saturation needs long runs of identical sampled values. The bench feeds 70 consecutive ones and then 140 consecutive zeros, and checks that the code holds at each end. Every fifteenth bit, the bench also raises `go` again during the run to show that the request is ignored. A bench model runs alongside the design and predicts every output on every clock, including the tick count derived from a slow oscillator divided in the bench.

// File: rtl/jitter_bit_ctrl.sv
module jitter_bit_ctrl #(
  parameter int PRESCALE = 4,
  parameter int COARSE_W = 3,
  parameter int FINE_W   = 4,
  parameter int LEN_W    = 8,
  parameter int TICK_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [LEN_W-1:0]    pulse_len,
  input  logic                slow_osc,
  input  logic                sample_in,
  output logic                slow_en,
  output logic                fast_arm,
  output logic                lfsr_rst,
  output logic                samp_rst,
  output logic [COARSE_W-1:0] coarse_code,
  output logic [FINE_W-1:0]   fine_code,
  output logic                bit_out,
  output logic                done,
  output logic                busy,
  output logic [TICK_W-1:0]   tick_cnt
);
  localparam int CODE_W = COARSE_W + FINE_W;
  localparam int PS_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [PS_W-1:0]   PS_LAST  = PS_W'(PRESCALE - 1);

  typedef enum logic [1:0] {IDLE, RUN, CAPT} phase_t;

  phase_t            phase;
  logic [LEN_W-1:0]  len_left;
  logic [CODE_W-1:0] code;
  logic [PS_W-1:0]   ps_cnt;
  logic [2:0]        osc_sync;
  logic              osc_rise;

  assign slow_en  = (phase == RUN);
  assign fast_arm = (phase == RUN);
  assign lfsr_rst = (phase == IDLE);
  assign samp_rst = (phase == IDLE);
  assign busy     = (phase != IDLE);
  assign {coarse_code, fine_code} = code;
  assign osc_rise = osc_sync[1] & ~osc_sync[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_sync <= '0;
    else        osc_sync <= {osc_sync[1:0], slow_osc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= IDLE;
      len_left <= '0;
      code     <= CODE_MID;
      bit_out  <= 1'b0;
      done     <= 1'b0;
      ps_cnt   <= '0;
      tick_cnt <= '0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        IDLE: if (go) begin
          phase    <= RUN;
          len_left <= (pulse_len == '0) ? '0 : pulse_len - 1'b1;
          ps_cnt   <= '0;
          tick_cnt <= '0;
        end
        RUN: begin
          if (osc_rise) begin
            if (ps_cnt == PS_LAST) begin
              ps_cnt   <= '0;
              tick_cnt <= tick_cnt + 1'b1;
            end else begin
              ps_cnt <= ps_cnt + 1'b1;
            end
          end
          if (len_left == '0) phase <= CAPT;
          else                len_left <= len_left - 1'b1;
        end
        CAPT: begin
          phase   <= IDLE;
          done    <= 1'b1;
          bit_out <= sample_in;
          if (sample_in && code != CODE_MAX)      code <= code + 1'b1;
          else if (!sample_in && code != '0)      code <= code - 1'b1;
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jbc_checker.sv
module jbc_checker #(
  parameter int CODE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slow_en,
  input logic              fast_arm,
  input logic              lfsr_rst,
  input logic              samp_rst,
  input logic              busy,
  input logic              done,
  input logic              bit_out,
  input logic [CODE_W-1:0] code
);
  localparam int CMAX = (1 << CODE_W) - 1;

  AST_RUN_RESETS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    slow_en |-> (fast_arm && !lfsr_rst && !samp_rst && busy)); // R2
  AST_CAPT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(slow_en) && !slow_en) |-> (busy && !samp_rst)); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && !$past(slow_en))); // R5
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(code) && $stable(bit_out))); // R8
  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((int'(code) == int'($past(code)) + 1) || (int'(code) == int'($past(code)) - 1)
              || (code == $past(code)))); // R6
  AST_CODE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (int'($past(code)) == CMAX || $past(code) == '0)) |-> !(int'(code) == CMAX && $past(code) == '0)
      && !(code == '0 && int'($past(code)) == CMAX)); // R7
endmodule

bind jitter_bit_ctrl jbc_checker #(.CODE_W(COARSE_W + FINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .fast_arm(fast_arm),
  .lfsr_rst(lfsr_rst), .samp_rst(samp_rst), .busy(busy), .done(done),
  .bit_out(bit_out), .code({coarse_code, fine_code})
);

// File: tb/jitter_bit_ctrl_test.sv
`timescale 1ns/1ps
module jitter_bit_ctrl_test;
  logic clk = 0, rst_n = 0, go = 0, slow_osc = 0, sample_in = 0;
  logic [7:0] pulse_len = 8'd1;
  logic slow_en, fast_arm, lfsr_rst, samp_rst, bit_out, done, busy;
  logic [2:0] coarse_code;
  logic [3:0] fine_code;
  logic [7:0] tick_cnt;

  int errors = 0, checks = 0, cycles = 0, osc_div = 0;
  // reference model state
  int m_phase = 0, m_cnt = 0, m_code = 64, m_bit = 0, m_done = 0;
  int m_ps = 0, m_ticks = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;

  always #10 clk = ~clk;

  jitter_bit_ctrl uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int rise;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_code = 64; m_bit = 0; m_done = 0;
      m_ps = 0; m_ticks = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      rise = (m_s2 == 1 && m_s3 == 0);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = slow_osc;
      m_done = 0;
      case (m_phase)
        0: if (go) begin
          m_phase = 1; m_cnt = (pulse_len == 0) ? 0 : pulse_len - 1;
          m_ps = 0; m_ticks = 0;
        end
        1: begin
          if (rise) begin
            if (m_ps == 3) begin m_ps = 0; m_ticks = (m_ticks + 1) % 256; end
            else m_ps++;
          end
          if (m_cnt == 0) m_phase = 2; else m_cnt--;
        end
        default: begin
          m_bit = sample_in; m_phase = 0; m_done = 1;
          if (sample_in && m_code < 127) m_code++;
          else if (!sample_in && m_code > 0) m_code--;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    osc_div++;
    if (osc_div == 3) begin osc_div = 0; slow_osc = ~slow_osc; end
    if (rst_n) begin
      check(slow_en == (m_phase == 1) && fast_arm == (m_phase == 1), "R2 enables", slow_en, m_phase == 1);
      check(samp_rst == (m_phase == 0) && lfsr_rst == (m_phase == 0), "R4 resets", samp_rst, m_phase == 0);
      check(busy == (m_phase != 0), "R3 busy", busy, m_phase != 0);
      check(done == m_done, "R5 done", done, m_done);
      check(bit_out == m_bit, "R4 bit_out", bit_out, m_bit);
      check({coarse_code, fine_code} == m_code, "R6 R8 code", {coarse_code, fine_code}, m_code);
      check(tick_cnt == m_ticks, "R9 tick_cnt", tick_cnt, m_ticks);
    end
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_bit(input int pl, input bit sbit, input bit extra_go);
    int on_cnt = 0, exp_len;
    exp_len = (pl == 0) ? 1 : pl;
    @(negedge clk);
    pulse_len = pl[7:0]; sample_in = sbit; go = 1;
    @(negedge clk);
    go = extra_go;
    for (int i = 0; i < 400; i++) begin
      if (slow_en) on_cnt++;
      if (done) break;
      @(negedge clk);
      go = 0;
    end
    check(on_cnt == exp_len, "R2 R3 run length", on_cnt, exp_len);
    check(done && bit_out == sbit && !busy, "R5 done with new bit", bit_out, sbit);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!slow_en && !fast_arm && lfsr_rst && samp_rst && !busy && !done && !bit_out,
          "R1 idle outputs", busy, 0);
    check(coarse_code == 3'd4 && fine_code == 4'd0, "R1 mid code",
          {coarse_code, fine_code}, 64);
    rst_n = 1;
    run_bit(1, 1, 0);
    run_bit(2, 0, 0);
    run_bit(5, 1, 1);
    run_bit(0, 0, 0);
    run_bit(40, 1, 0);
    run_bit(33, 1, 1);
    check(tick_cnt != 0, "R9 ticks seen on long run", tick_cnt, 1);
    for (int i = 0; i < 70; i++) run_bit(1 + i % 4, 1, (i % 15) == 3);
    check(coarse_code == 3'd7 && fine_code == 4'd15, "R7 top saturation",
          {coarse_code, fine_code}, 127);
    for (int i = 0; i < 140; i++) run_bit(1 + i % 3, 0, (i % 15) == 7);
    check(coarse_code == 3'd0 && fine_code == 4'd0, "R7 bottom saturation",
          {coarse_code, fine_code}, 0);
    for (int i = 0; i < 16; i++) run_bit(1, 1, 0);
    check(coarse_code == 3'd1 && fine_code == 4'd0, "R6 fine carry into coarse",
          {coarse_code, fine_code}, 16);
    run_bit(1, 0, 0);
    check(coarse_code == 3'd0 && fine_code == 4'd15, "R6 fine borrow from coarse",
          {coarse_code, fine_code}, 15);
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule